// File: doc/BRIEF.md
# Buffered Serial Flash Page Programmer

This block sends page-program frames to a serial NOR flash over a single-lane SPI bus in mode 0. Software first asks for the write buffer to be enabled. It waits until the enable readback follows the request. It then pushes 32-bit words into the page-data port until a full page of `PAGE_BYTES` bytes (128 by default) is held. A start request then sends the program opcode, then the target address with the most significant byte first (3 or 4 bytes), then the whole page. Each word is unpacked least significant byte first. The command-busy flag stays high until chip select is released.

When the buffer is disabled, the same start request sends the opcode, the address and one data byte taken from a separate single-byte input. If a start request arrives while the buffer is enabled but not full, no frame is sent, the busy flag never rises and a short-fill error flag is set. The opcode, address, address length and single byte are latched when a frame is launched.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, chip select is high (inactive), the serial clock and data lines are low, and the busy, enable-readback and error flags are all low.
- R2: When `buf_en_req` differs from `buf_en_ack` and no frame is in progress, `buf_en_ack` takes the requested value exactly `EN_LAT` rising clock edges later (3 by default). It never changes while a frame is in progress.
- R3: In buffered mode, a frame is sent MSB first on every byte. Its order is: the opcode, then the address most significant byte first (4 bytes when `addr_4byte` is 1, otherwise bits 23:0 as 3 bytes), then `PAGE_BYTES` data bytes. Data byte 4*n+k is bits 8k+7:8k of the n-th pushed word.
- R4: With `buf_en_ack` low, a start sends the opcode, the address (as in R3) and exactly one data byte equal to `single_byte`.
- R5: `cmd_busy` rises on the edge after an accepted `cmd_start` and falls on the same edge that returns chip select high after the last bit. Chip select is never low while `cmd_busy` is low.
- R6: A start with the buffer enabled but fewer than `PAGE_BYTES` bytes loaded leaves chip select high and `cmd_busy` low, and sets `fill_short_err`. The next launched frame clears the flag.
- R7: Words pushed while a frame is in progress are not stored.
- R8: The fill count returns to zero when a buffered frame completes and whenever the enable readback is low. A later page therefore needs a full set of new words before it can be sent.
- R9: Words pushed after the page is full are ignored, and the frame carries only the first `PAGE_BYTES` bytes.
- R10: The bus runs in SPI mode 0. The serial clock is low while chip select is high, and the data line changes only while the serial clock is low. Each clock phase lasts `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_en_req | input | 1 | Requested write-buffer enable level |
| buf_en_ack | output | 1 | Enable readback, updated after the mode switch |
| wdata_push | input | 1 | Push `wdata_word` into the page buffer |
| wdata_word | input | 32 | Four page bytes, first byte in bits 7:0 |
| single_byte | input | 8 | Data byte for the unbuffered program |
| prog_opcode | input | 8 | Program opcode sent first |
| prog_addr | input | 32 | Flash target address |
| addr_4byte | input | 1 | 1: four address bytes, 0: three |
| cmd_start | input | 1 | Request a program frame |
| cmd_busy | output | 1 | Command bit, high while a frame runs |
| fill_short_err | output | 1 | Set by a start on a partly filled buffer |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |

## Verification
A wrong fill count shows at the ports as an unexpected short-fill error, or as a frame that starts too early. Either appears on the edge after the start request, so the bench tests the count by starting one word short of a page. Errors in byte selection or lane order corrupt a specific captured byte within a few bus clocks of its slot, and the bench compares every byte of each frame. A stuck or early end of the shifter shows as a wrong captured frame length, or as the busy flag falling before chip select rises.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
  // Number of address bytes sent for the selected mode.
  function automatic int unsigned addr_len(input logic four);
    return four ? 4 : 3;
  endfunction

  // Total bytes in a frame: opcode, address and payload.
  function automatic int unsigned frame_len(input logic four, input logic paged,
                                            input int unsigned page);
    return 1 + addr_len(four) + (paged ? page : 1);
  endfunction

  // Address byte in send order (0 = most significant byte of the frame).
  function automatic logic [7:0] addr_byte(input logic [31:0] a, input logic four,
                                           input int unsigned pos);
    int unsigned sh;
    sh = 8 * (addr_len(four) - 1 - pos);
    return 8'(a >> sh);
  endfunction

  // Byte k of a page held as little-endian 32-bit words.
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] k);
    return w[8*k +: 8];
  endfunction
endpackage

// File: rtl/fpw_mode_ctl.sv
module fpw_mode_ctl #(
  parameter int EN_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic hold,
  output logic en_ack
);
  localparam int CW = (EN_LAT > 1) ? $clog2(EN_LAT + 1) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      en_ack <= 1'b0;
    end else if (hold || (en_req == en_ack)) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(EN_LAT - 1)) begin
      cnt_q  <= '0;
      en_ack <= en_req;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpw_page_buf.sv
module fpw_page_buf #(
  parameter int PAGE_BYTES = 128
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  push,
  input  logic [31:0]                           word,
  input  logic                                  clr,
  input  logic [$clog2(PAGE_BYTES)-1:0]         rd_idx,
  output logic [7:0]                            rd_byte,
  output logic [$clog2(PAGE_BYTES+1)-1:0]       fill,
  output logic                                  full
);
  import fpw_pkg::*;

  localparam int WORD_BYTES = 4;
  localparam int NW         = PAGE_BYTES / WORD_BYTES;
  localparam int IDX_W      = $clog2(PAGE_BYTES);
  localparam int CNT_W      = $clog2(PAGE_BYTES + 1);

  logic [31:0]      mem_q [NW];
  logic             accept;
  logic [IDX_W-3:0] wr_widx;

  assign full    = (fill == CNT_W'(PAGE_BYTES));
  assign accept  = push && !full;
  assign wr_widx = fill[IDX_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill <= '0;
    else if (clr)    fill <= '0;
    else if (accept) fill <= fill + CNT_W'(WORD_BYTES);
  end

  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (accept && (wr_widx == (IDX_W-2)'(i))) mem_q[i] <= word;
    end
  end

  assign rd_byte = lane_byte(mem_q[rd_idx[IDX_W-1:2]], rd_idx[1:0]);
endmodule

// File: rtl/fpw_shifter.sv
module fpw_shifter #(
  parameter int CLK_DIV = 2,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] total_bytes,
  input  logic [7:0]       cur_byte,
  output logic [LEN_W-1:0] byte_idx,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic             last_edge
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic          active_q;
  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic          phase_end;

  assign phase_end = active_q && (div_q == DW'(CLK_DIV - 1));
  assign last_edge = phase_end && sclk && (bit_q == 3'd7) &&
                     (byte_idx == total_bytes - 1'b1);
  assign cs_n      = !active_q;
  assign mosi      = active_q ? cur_byte[3'd7 - bit_q] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      byte_idx <= '0;
      sclk     <= 1'b0;
    end else if (!active_q) begin
      if (go) begin
        active_q <= 1'b1;
        div_q    <= '0;
        bit_q    <= '0;
        byte_idx <= '0;
        sclk     <= 1'b0;
      end
    end else if (phase_end) begin
      div_q <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (last_edge) begin
          active_q <= 1'b0;
        end else if (bit_q == 3'd7) begin
          bit_q    <= '0;
          byte_idx <= byte_idx + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int PAGE_BYTES = 128,
  parameter int CLK_DIV    = 2,
  parameter int EN_LAT     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        buf_en_req,
  output logic        buf_en_ack,
  input  logic        wdata_push,
  input  logic [31:0] wdata_word,
  input  logic [7:0]  single_byte,
  input  logic [7:0]  prog_opcode,
  input  logic [31:0] prog_addr,
  input  logic        addr_4byte,
  input  logic        cmd_start,
  output logic        cmd_busy,
  output logic        fill_short_err,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi
);
  import fpw_pkg::*;

  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam int LEN_W = $clog2(PAGE_BYTES + 6);

  logic             paged_q, four_q;
  logic [7:0]       opc_q, sbyte_q;
  logic [31:0]      addr_q;
  logic             start_req, short_start, launch, frame_done;
  logic             page_full;
  logic [CNT_W-1:0] fill_bytes;
  logic [LEN_W-1:0] sh_idx, total;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       buf_byte, cur_byte;

  assign start_req   = cmd_start && !cmd_busy;
  assign short_start = start_req && buf_en_ack && !page_full;
  assign launch      = start_req && !short_start;
  assign total       = LEN_W'(frame_len(four_q, paged_q, PAGE_BYTES));

  fpw_mode_ctl #(.EN_LAT(EN_LAT)) u_mode (
    .clk(clk), .rst_n(rst_n), .en_req(buf_en_req), .hold(cmd_busy), .en_ack(buf_en_ack)
  );

  fpw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .push(wdata_push && buf_en_ack && !cmd_busy), .word(wdata_word),
    .clr(!buf_en_ack || (frame_done && paged_q)),
    .rd_idx(rd_idx), .rd_byte(buf_byte), .fill(fill_bytes), .full(page_full)
  );

  fpw_shifter #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(launch), .total_bytes(total), .cur_byte(cur_byte),
    .byte_idx(sh_idx), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .last_edge(frame_done)
  );

  always_comb begin
    int unsigned idx, nab;
    idx    = 32'(sh_idx);
    nab    = addr_len(four_q);
    rd_idx = IDX_W'(idx - 1 - nab);
    if (idx == 0)        cur_byte = opc_q;
    else if (idx <= nab) cur_byte = addr_byte(addr_q, four_q, idx - 1);
    else if (paged_q)    cur_byte = buf_byte;
    else                 cur_byte = sbyte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_busy       <= 1'b0;
      fill_short_err <= 1'b0;
      paged_q        <= 1'b0;
      four_q         <= 1'b0;
      opc_q          <= '0;
      sbyte_q        <= '0;
      addr_q         <= '0;
    end else begin
      if (short_start) fill_short_err <= 1'b1;
      if (launch) begin
        cmd_busy       <= 1'b1;
        fill_short_err <= 1'b0;
        paged_q        <= buf_en_ack;
        four_q         <= addr_4byte;
        opc_q          <= prog_opcode;
        sbyte_q        <= single_byte;
        addr_q         <= prog_addr;
      end else if (frame_done) begin
        cmd_busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_page_writer_chk.sv
module flash_page_writer_chk #(
  parameter int PAGE_BYTES = 128,
  parameter int CNT_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic             en_ack,
  input logic             err,
  input logic             short_start,
  input logic             frame_done,
  input logic [CNT_W-1:0] fill
);
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R10
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sclk && $past(sclk)) |-> $stable(mosi)); // R10
  AST_CS_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy); // R5
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> (!busy && cs_n)); // R5
  AST_SHORT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n) short_start |=> (err && !busy && cs_n)); // R6
  AST_EN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(en_ack)); // R2
  AST_FILL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(fill)); // R7
  AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n) (fill <= CNT_W'(PAGE_BYTES))); // R9
endmodule

bind flash_page_writer flash_page_writer_chk #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .busy(cmd_busy), .en_ack(buf_en_ack), .err(fill_short_err),
  .short_start(short_start), .frame_done(frame_done), .fill(fill_bytes)
);

// File: tb/flash_page_writer_test.sv
`timescale 1ns/1ps
module flash_page_writer_test;
  localparam int PAGE = 128;
  localparam int NW   = PAGE / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic buf_en_req = 0, wdata_push = 0, addr_4byte = 0, cmd_start = 0;
  logic [31:0] wdata_word = '0, prog_addr = '0;
  logic [7:0] single_byte = '0, prog_opcode = '0;
  logic buf_en_ack, cmd_busy, fill_short_err, spi_sclk, spi_cs_n, spi_mosi;

  int checks = 0, errors = 0;
  logic [31:0] model_w [NW];
  int model_cnt = 0;
  logic model_en = 0;
  logic [7:0] cap [200];
  int cap_bits = 0;
  int cs_falls = 0;

  always #2 clk = ~clk;

  flash_page_writer uut (.*);

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cap[cap_bits/8] = {cap[cap_bits/8][6:0], spi_mosi};
    cap_bits++;
  end
  always @(negedge spi_cs_n) cs_falls++;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] exp_byte(int k, logic [7:0] opc, logic [31:0] a,
                                          logic four, logic paged, logic [7:0] sb);
    int na = four ? 4 : 3;
    if (k == 0) return opc;
    if (k <= na) return a[8*(na-k) +: 8];
    if (!paged) return sb;
    return model_w[(k-1-na)/4][8*((k-1-na)%4) +: 8];
  endfunction

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    wdata_push = 1; wdata_word = w;
    if (model_en && !cmd_busy && model_cnt < NW) begin
      model_w[model_cnt] = w; model_cnt++;
    end
    @(negedge clk);
    wdata_push = 0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    buf_en_req = v;
    repeat (4) @(negedge clk);
    check(buf_en_ack == v, "R2", "enable readback", buf_en_ack, v);
    model_en = v;
    if (!v) model_cnt = 0;
  endtask

  task automatic short_start_chk(input string req);
    int f0 = cs_falls;
    @(negedge clk); cmd_start = 1;
    @(negedge clk); cmd_start = 0;
    check(fill_short_err && !cmd_busy, req, "short start err/busy",
          {fill_short_err, cmd_busy}, 2'b10);
    repeat (20) @(negedge clk);
    check(cs_falls == f0 && spi_cs_n, req, "no bus activity on short start", cs_falls - f0, 0);
  endtask

  task automatic run_frame(input string req, input logic [7:0] opc, input logic [31:0] a,
                           input logic four, input logic [7:0] sb, input bit push_during);
    logic paged = model_en;
    int n = 1 + (four ? 4 : 3) + (paged ? PAGE : 1);
    int bad = -1;
    @(negedge clk);
    prog_opcode = opc; prog_addr = a; addr_4byte = four; single_byte = sb;
    cap_bits = 0; cmd_start = 1;
    @(negedge clk); cmd_start = 0;
    check(cmd_busy && !fill_short_err, "R5", "busy after start", cmd_busy, 1);
    if (push_during) for (int i = 0; i < 6; i++) push($urandom);
    while (cmd_busy) @(negedge clk);
    check(spi_cs_n && !spi_sclk, "R5", "cs released with busy low", spi_cs_n, 1);
    check(cap_bits == 8*n, req, "frame bit count", cap_bits, 8*n);
    for (int k = 0; k < n; k++)
      if (bad < 0 && cap[k] !== exp_byte(k, opc, a, four, paged, sb)) bad = k;
    check(bad < 0, req, $sformatf("frame byte %0d", bad),
          bad < 0 ? 0 : cap[bad], bad < 0 ? 0 : exp_byte(bad, opc, a, four, paged, sb));
    if (paged) model_cnt = 0;
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    check(spi_cs_n && !spi_sclk && !spi_mosi, "R1", "bus idle at reset",
          {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
    check(!cmd_busy && !buf_en_ack && !fill_short_err, "R1", "flags at reset",
          {cmd_busy, buf_en_ack, fill_short_err}, 0);
    rst_n = 1;

    // R2: exact enable latency
    @(negedge clk); buf_en_req = 1;
    repeat (2) @(negedge clk);
    check(buf_en_ack == 0, "R2", "readback before latency", buf_en_ack, 0);
    @(negedge clk);
    check(buf_en_ack == 1, "R2", "readback at latency", buf_en_ack, 1);
    model_en = 1;

    // R6: partly filled buffer
    for (int i = 0; i < 5; i++) push($urandom);
    short_start_chk("R6");

    // R9: overfill, extra words dropped
    for (int i = 0; i < 35; i++) push($urandom);
    run_frame("R9", 8'h02, 32'h00A1B2C3, 0, 8'h00, 0);
    check(!fill_short_err, "R6", "error cleared by launch", fill_short_err, 0);

    // R8: fill count reset after frame; R7 pushes during a frame
    for (int i = 0; i < NW; i++) push(32'h03020100 + 32'h04040404 * i);
    run_frame("R3", 8'h12, 32'hDEADBEEF, 1, 8'h00, 1);
    for (int i = 0; i < NW-1; i++) push($urandom);
    short_start_chk("R8");
    push($urandom);
    run_frame("R7", 8'h12, 32'h01234567, 1, 8'h00, 0);

    // R8: disabling clears the count
    for (int i = 0; i < NW; i++) push($urandom);
    set_en(0);
    set_en(1);
    short_start_chk("R8");

    // R3: random pages
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < NW; i++) push($urandom);
      run_frame("R3", 8'($urandom), $urandom, 1'($urandom), 8'h00, 0);
    end

    // R4: unbuffered single byte, words ignored while disabled
    set_en(0);
    push(32'hFFFFFFFF);
    run_frame("R4", 8'h02, 32'h00123456, 0, 8'hA5, 0);
    for (int r = 0; r < 4; r++)
      run_frame("R4", 8'($urandom), $urandom, 1'($urandom), 8'($urandom), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule